// File: doc/BRIEF.md
# Hash Message Expansion Unit

This block turns one 512-bit message block into the stream of per-round word pairs that a 64-round hash compression core consumes. A block is offered on a one-cycle start strobe. The block splits it into sixteen 32-bit words, reading the bytes in big-endian order, and then streams one round per cycle. Each round carries the round word W[j], the mixed word W'[j] = W[j] ^ W[j+4], and the round index j, for j from 0 to 63.

Words past the sixteenth come from a rotate/XOR recurrence over earlier words, with P1(x) = x ^ rotl(x,15) ^ rotl(x,23). Only a sliding window of sixteen words is stored, never the full expanded array. The window moves one word each time a round pair is taken. The output side is a valid/ready stream. The input side stays closed until all 64 pairs of the current block have been taken. Padding, length encoding and the compression rounds belong to neighbouring blocks.

Top module: `msg_expand`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0, `in_ready` = 1 and `out_round` = 0. This holds even when a block is part-way through its rounds.
- R2: Message byte k sits at `in_block[8k+7:8k]`. For i = 0..15, W[i] is {byte 4i, byte 4i+1, byte 4i+2, byte 4i+3}, so the lower-numbered byte is the most significant.
- R3: For j >= 16, W[j] = P1(W[j-16] ^ W[j-9] ^ rotl(W[j-3],15)) ^ rotl(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rotl(x,15) ^ rotl(x,23).
- R4: In the cycle that presents round j, `out_wx` equals W[j] ^ W[j+4].
- R5: Rounds are presented in increasing order 0..63, with `out_round` = j. After round 63 is taken, `out_valid` is 0 in the next cycle.
- R6: A start strobe taken while `in_ready` = 1 makes round 0 valid in the cycle after that edge.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_w`, `out_wx` and `out_round` stay unchanged into the next cycle.
- R8: `in_ready` is 0 while rounds of a block are still outstanding. A start strobe in that time has no effect on the stream.
- R9: `in_ready` is 1 in the cycle after round 63 is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Strobe: `in_block` holds a new message block |
| in_block | input | 512 | Message block, byte k at bits [8k+7:8k] |
| in_ready | output | 1 | High when a new block can be taken |
| out_valid | output | 1 | A round pair is presented |
| out_ready | input | 1 | The consumer takes the presented pair at this edge |
| out_w | output | 32 | Round word W[j] |
| out_wx | output | 32 | Mixed word W[j] ^ W[j+4] |
| out_round | output | 6 | Round index j |

## Verification
The start strobe and every taken round are registered once. Round 0 must therefore be visible one cycle after the accepting edge. After each edge where `out_ready` was high, the next round must be visible. After each edge where `out_ready` was low, the same round must still be visible. The bench drives its inputs and samples the outputs on the falling edge. Between two falling edges there is exactly one rising edge, so the bench moves its behavioural round pointer only after a cycle in which it drove `out_ready` high, and compares all outputs against that pointer on every cycle. A start strobe inside a block and a reset partway through a block are checked at the falling edge right after the rising edge that saw them.

// File: rtl/msg_expand_pkg.sv
package msg_expand_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

    // rotation amounts used by the recurrence and its permutation
    localparam int ROT_NEAR = 15;
    localparam int ROT_BACK = 7;
    localparam int ROT_P1_A = 15;
    localparam int ROT_P1_B = 23;

    // distance of each recurrence tap behind the word being generated
    localparam int DIST_FAR  = 16;
    localparam int DIST_BACK = 13;
    localparam int DIST_MID  = 9;
    localparam int DIST_SIX  = 6;
    localparam int DIST_NEAR = 3;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t perm_p1(input word_t x);
        return x ^ rotl(x, ROT_P1_A) ^ rotl(x, ROT_P1_B);
    endfunction

endpackage

// File: rtl/msg_expand_unpack.sv
module msg_expand_unpack
    import msg_expand_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int BLK_W = NUM_WORDS * WORD_W
) (
    input  logic [BLK_W-1:0]                  blk,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);

    // byte k lives at blk[8k +: 8]; the lowest-numbered byte of each word
    // becomes its most significant byte
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            for (int b = 0; b < BYTES_PER_WORD; b++) begin
                words[i][WORD_W-1-BYTE_W*b -: BYTE_W] =
                    blk[BYTE_W*(BYTES_PER_WORD*i + b) +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/msg_expand_next.sv
module msg_expand_next
    import msg_expand_pkg::*;
(
    input  word_t tap_far,
    input  word_t tap_back,
    input  word_t tap_mid,
    input  word_t tap_six,
    input  word_t tap_near,
    output word_t next_word
);

    word_t mixed;

    always_comb begin
        mixed     = tap_far ^ tap_mid ^ rotl(tap_near, ROT_NEAR);
        next_word = perm_p1(mixed) ^ rotl(tap_back, ROT_BACK) ^ tap_six;
    end

endmodule

// File: rtl/msg_expand.sv
module msg_expand
    import msg_expand_pkg::*;
#(
    parameter int NUM_ROUNDS = 64,
    parameter int WIN_WORDS  = 16,
    parameter int LOOKAHEAD  = 4,
    localparam int RW    = $clog2(NUM_ROUNDS),
    localparam int BLK_W = WIN_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic [BLK_W-1:0]  in_block,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_w,
    output logic [WORD_W-1:0] out_wx,
    output logic [RW-1:0]     out_round
);

    localparam logic [RW-1:0] LAST_ROUND = RW'(NUM_ROUNDS - 1);
    // window slot 0 holds W[j]; a word d behind W[j+WIN_WORDS] sits in slot WIN_WORDS-d
    localparam int IDX_FAR  = WIN_WORDS - DIST_FAR;
    localparam int IDX_BACK = WIN_WORDS - DIST_BACK;
    localparam int IDX_MID  = WIN_WORDS - DIST_MID;
    localparam int IDX_SIX  = WIN_WORDS - DIST_SIX;
    localparam int IDX_NEAR = WIN_WORDS - DIST_NEAR;

    typedef struct packed {
        logic                                busy;
        logic [RW-1:0]                       round;
        logic [WIN_WORDS-1:0][WORD_W-1:0]    win;
    } state_t;

    state_t st_d, st_q;

    logic [WIN_WORDS-1:0][WORD_W-1:0] load_words;
    word_t                            gen_word;
    logic                             accept;
    logic                             fire;

    msg_expand_unpack #(
        .NUM_WORDS (WIN_WORDS)
    ) u_unpack (
        .blk   (in_block),
        .words (load_words)
    );

    msg_expand_next u_next (
        .tap_far   (st_q.win[IDX_FAR]),
        .tap_back  (st_q.win[IDX_BACK]),
        .tap_mid   (st_q.win[IDX_MID]),
        .tap_six   (st_q.win[IDX_SIX]),
        .tap_near  (st_q.win[IDX_NEAR]),
        .next_word (gen_word)
    );

    always_comb begin
        st_d   = st_q;
        accept = in_start && !st_q.busy;
        fire   = st_q.busy && out_ready;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.round = '0;
            st_d.win   = load_words;
        end else if (fire) begin
            for (int k = 0; k < WIN_WORDS - 1; k++) begin
                st_d.win[k] = st_q.win[k+1];
            end
            st_d.win[WIN_WORDS-1] = gen_word;
            if (st_q.round == LAST_ROUND) begin
                st_d.busy  = 1'b0;
                st_d.round = '0;
            end else begin
                st_d.round = st_q.round + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_w     = st_q.win[0];
    assign out_wx    = st_q.win[0] ^ st_q.win[LOOKAHEAD];
    assign out_round = st_q.round;

endmodule

// File: rtl/msg_expand_chk.sv
module msg_expand_chk #(
    parameter int NUM_ROUNDS = 64,
    localparam int RW = $clog2(NUM_ROUNDS)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_start,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [31:0]   out_w,
    input logic [31:0]   out_wx,
    input logic [RW-1:0] out_round
);

    localparam logic [RW-1:0] LAST_ROUND = RW'(NUM_ROUNDS - 1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready && out_round == '0));

    // R6
    first_round_chk: assert property (@(posedge clk) disable iff (rst)
        (in_start && in_ready) |=> (out_valid && out_round == '0));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_w) && $stable(out_wx) && $stable(out_round)));

    // R5
    round_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_round != LAST_ROUND) |=>
            (out_valid && out_round == $past(out_round) + 1'b1));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_round == LAST_ROUND) |=>
            (!out_valid && in_ready));

endmodule

bind msg_expand msg_expand_chk #(
    .NUM_ROUNDS (NUM_ROUNDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_start  (in_start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_w     (out_w),
    .out_wx    (out_wx),
    .out_round (out_round)
);

// File: tb/msg_expand_bench.sv
module msg_expand_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 64;
    localparam int WDOG       = 50000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_start = 1'b0;
    logic [511:0] in_block = '0;
    logic         out_ready = 1'b0;
    logic         in_ready, out_valid;
    logic [31:0]  out_w, out_wx;
    logic [5:0]   out_round;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] ref_w[$];

    msg_expand u_msg_expand (
        .clk       (clk),
        .rst       (rst),
        .in_start  (in_start),
        .in_block  (in_block),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_w     (out_w),
        .out_wx    (out_wx),
        .out_round (out_round)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] p1f(input logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    // behavioural model: big-endian word split (R2), then recurrence (R3) to W[67]
    task automatic build_ref(input logic [7:0] bytes[64]);
        ref_w.delete();
        for (int i = 0; i < 16; i++)
            ref_w.push_back({bytes[4*i], bytes[4*i+1], bytes[4*i+2], bytes[4*i+3]});
        for (int j = 16; j < NR + 4; j++)
            ref_w.push_back(p1f(ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15))
                            ^ rl(ref_w[j-13], 7) ^ ref_w[j-6]);
    endtask

    function automatic logic [511:0] pack(input logic [7:0] bytes[64]);
        logic [511:0] v;
        for (int k = 0; k < 64; k++) v[8*k +: 8] = bytes[k];
        return v;
    endfunction

    function automatic bit ready_pat(input int mode, input int t);
        case (mode)
            0:       return 1'b1;
            1:       return (t % 3) != 0;
            default: return ((t * 7) % 5) < 2;
        endcase
    endfunction

    task automatic check_idle(input string tag);
        check({tag, " out_valid idle"}, {31'b0, out_valid}, 32'd0);
        check({tag, " in_ready idle"}, {31'b0, in_ready}, 32'd1);
        check({tag, " out_round idle"}, {26'b0, out_round}, 32'd0);
    endtask

    task automatic run_block(input logic [7:0] bytes[64], input int mode, input bit poke);
        int  idx;
        int  t;
        bit  held;
        bit  poked;
        logic [7:0] junk[64];
        build_ref(bytes);
        for (int k = 0; k < 64; k++) junk[k] = 8'hA5 ^ 8'(k);
        @(negedge clk);
        check("R9 in_ready before start", {31'b0, in_ready}, 32'd1);
        in_block = pack(bytes);
        in_start = 1'b1;
        @(negedge clk);
        in_start = 1'b0;
        idx   = 0;
        t     = 0;
        held  = 1'b0;
        poked = 1'b0;
        while (idx < NR) begin
            check($sformatf("%s out_valid round %0d", (t == 0) ? "R6" : "R5", idx),
                  {31'b0, out_valid}, 32'd1);
            check($sformatf("%s out_round", held ? "R7" : "R5"), {26'b0, out_round}, idx);
            check($sformatf("%s out_w round %0d", poked ? "R8" : (idx < 16 ? "R2" : "R3"), idx),
                  out_w, ref_w[idx]);
            check($sformatf("R4 out_wx round %0d", idx), out_wx, ref_w[idx] ^ ref_w[idx+4]);
            check("R8 in_ready busy", {31'b0, in_ready}, 32'd0);
            poked = 1'b0;
            if (poke && idx == 10 && !held) begin
                in_block = pack(junk);
                in_start = 1'b1;
                poked    = 1'b1;
            end
            out_ready = ready_pat(mode, t);
            held      = !out_ready;
            @(negedge clk);
            in_start = 1'b0;
            if (out_ready) idx++;
            t++;
        end
        out_ready = 1'b0;
        check("R5 out_valid after round 63", {31'b0, out_valid}, 32'd0);
        check("R9 in_ready after round 63", {31'b0, in_ready}, 32'd1);
    endtask

    initial begin
        logic [7:0] zero_b[64];
        logic [7:0] abc_b[64];
        logic [7:0] ramp_b[64];
        for (int k = 0; k < 64; k++) begin
            zero_b[k] = 8'h00;
            abc_b[k]  = 8'h00;
            ramp_b[k] = 8'(k * 37 + 5);
        end
        abc_b[0]  = 8'h61;
        abc_b[1]  = 8'h62;
        abc_b[2]  = 8'h63;
        abc_b[3]  = 8'h80;
        abc_b[63] = 8'h18;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1 after reset");

        run_block(zero_b, 0, 1'b0);
        run_block(abc_b, 1, 1'b0);
        run_block(ramp_b, 2, 1'b1);
        run_block(abc_b, 0, 1'b1);

        // R1: reset partway through a block
        build_ref(ramp_b);
        @(negedge clk);
        in_block = pack(ramp_b);
        in_start = 1'b1;
        @(negedge clk);
        in_start  = 1'b0;
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 out_round mid block", {26'b0, out_round}, 32'd5);
        out_ready = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R1 mid-block reset");

        run_block(ramp_b, 1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule